// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the line and frame timing for a parallel RGB panel. A horizontal pixel counter and a vertical line counter run across a programmed total. The block derives horizontal sync, vertical sync and a data-enable window from them, along with a pixel clock for the panel and the coordinates of the pixel inside the visible area. The counters advance only in cycles where the pixel clock enable is high, so the block runs from the system clock at any pixel rate up to half of it.

Window positions are absolute counts measured from the start of sync. The active start is the sync width plus the leading porch, and the active end is the start plus the visible size. The total is the active end plus the trailing porch. Positions are packed two to a 32-bit word. Timing values are captured only when a frame starts, so software may rewrite them while the raster runs. A stop request lets the frame in progress finish. A sticky stopped flag then rises, and software clears it before it starts the block again.

Top module: `lcd_raster_timing`

## Requirements
- R1: After reset the block is stopped. Each sync and enable output sits at its inactive level, which equals its polarity input. The pixel clock output is 0, both coordinates are 0 and the stopped flag is 0.
- R2: A start request with the stop request low starts the raster at pixel (0,0) on the next clock edge. A start request that arrives with the stop request high does not start it.
- R3: While running, the horizontal count advances by one only on cycles with the pixel clock enable high, and holds otherwise. Both counts wrap from their total minus 1 to 0. The line count advances when the horizontal count wraps. The total word holds the horizontal total in bits 31:16 and the vertical total in bits 15:0.
- R4: Horizontal sync is active while the horizontal count is below the 10-bit horizontal sync width. Vertical sync is active while the line count is below the 10-bit vertical sync width.
- R5: Data enable is active only while the horizontal count lies in [start, end) of the horizontal window and the line count lies in [start, end) of the vertical window. Each window word holds its start in bits 31:16 and its end in bits 15:0. The coordinate outputs give the count minus the window start while data enable is active, and 0 otherwise.
- R6: Each of the hsync, vsync and data-enable polarity inputs, when 1, makes its output active-low.
- R7: While running with the falling-edge select at 0, the pixel clock output is 0 in the cycle after each pixel advance and 1 in other cycles. With the select at 1 these levels are swapped. The output is 0 while stopped.
- R8: A stop request while running takes effect at the end of the current frame, on the advance out of the last pixel of the last line. If the request arrives on that advance, the block stops at once. At that point the outputs return to their stopped levels and the stopped flag rises.
- R9: The stopped flag stays at 1 until the clear input is pulsed. A stop request while the block is already stopped sets the flag on the next edge.
- R10: Sync widths, totals and window positions are sampled only at frame start. A change during a frame first affects the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pixEn | input | 1 | Pixel clock enable, at most every other cycle |
| hsyncWidth | input | 10 | Horizontal sync width in pixels |
| vsyncWidth | input | 10 | Vertical sync width in lines |
| totalWord | input | 32 | Horizontal total [31:16], vertical total [15:0] |
| hWindowWord | input | 32 | Horizontal active start [31:16], end [15:0] |
| vWindowWord | input | 32 | Vertical active start [31:16], end [15:0] |
| hsyncLow | input | 1 | Hsync active-low select |
| vsyncLow | input | 1 | Vsync active-low select |
| deLow | input | 1 | Data enable active-low select |
| fallEdge | input | 1 | Panel samples on the falling pixel clock edge |
| startReq | input | 1 | Start request |
| stopReq | input | 1 | Stop request, honoured at frame end |
| stoppedClr | input | 1 | Clears the stopped flag |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pclkOut | output | 1 | Pixel clock to the panel |
| xPos | output | 16 | Active-area column |
| yPos | output | 16 | Active-area row |
| stoppedFlag | output | 1 | Sticky stopped flag |

## Verification
The assertions check on every cycle that a rising stopped flag from the running state coincides with the last-pixel advance. They also check that the flag holds until cleared, and that data enable, the pixel clock and the coordinates stay quiet while stopped or outside the window. Only the bench scenarios can show the raster itself. Those scenarios cover the exact sync and window positions across whole frames, the wrap of both counters, polarity and edge inversion, a mid-frame width change that appears one frame later, and a stop request that lands either mid-frame or on the final pixel.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } rasterState_t;

  typedef struct packed {
    logic running;
    logic loadCfg;
    logic clearCnt;
  } rasterCtl_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       stoppedClr,
  input  logic       frameEnd,
  output rasterCtl_t ctl,
  output logic       stoppedFlag
);
  rasterState_t state, stateNext;
  logic stopNow;
  logic flagReg;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    stopNow     = 1'b0;
    ctl.running = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (startReq && !stopReq) begin
          stateNext    = ST_RUN;
          ctl.loadCfg  = 1'b1;
          ctl.clearCnt = 1'b1;
        end
      end
      ST_RUN: begin
        if (frameEnd) begin
          if (stopReq) begin
            stateNext    = ST_IDLE;
            ctl.clearCnt = 1'b1;
            stopNow      = 1'b1;
          end else begin
            ctl.loadCfg = 1'b1;
          end
        end else if (stopReq) begin
          stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (frameEnd) begin
          stateNext    = ST_IDLE;
          ctl.clearCnt = 1'b1;
          stopNow      = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      flagReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (stopNow || (state == ST_IDLE && stopReq))
        flagReg <= 1'b1;
      else if (stoppedClr)
        flagReg <= 1'b0;
    end
  end

  assign stoppedFlag = flagReg;
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  rasterCtl_t         ctl,
  input  logic [SYNC_W-1:0]  hsyncWidth,
  input  logic [SYNC_W-1:0]  vsyncWidth,
  input  logic [2*CNT_W-1:0] totalWord,
  input  logic [2*CNT_W-1:0] hWindowWord,
  input  logic [2*CNT_W-1:0] vWindowWord,
  input  logic               hsyncLow,
  input  logic               vsyncLow,
  input  logic               deLow,
  input  logic               fallEdge,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               pclkOut,
  output logic [CNT_W-1:0]   xPos,
  output logic [CNT_W-1:0]   yPos,
  output logic               frameEnd
);
  localparam int PAD_W = CNT_W - SYNC_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  hTotS, vTotS, hStartS, hEndS, vStartS, vEndS;
  logic [SYNC_W-1:0] hsWS, vsWS;
  logic [CNT_W-1:0]  hCnt, vCnt;
  logic              pixPhase;
  logic              advance, lastCol, lastRow;
  logic              hsAct, vsAct, inH, inV, deAct;

  // timing shadow, captured at frame start only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hTotS   <= '0;
      vTotS   <= '0;
      hStartS <= '0;
      hEndS   <= '0;
      vStartS <= '0;
      vEndS   <= '0;
      hsWS    <= '0;
      vsWS    <= '0;
    end else if (ctl.loadCfg) begin
      hTotS   <= totalWord[2*CNT_W-1:CNT_W];
      vTotS   <= totalWord[CNT_W-1:0];
      hStartS <= hWindowWord[2*CNT_W-1:CNT_W];
      hEndS   <= hWindowWord[CNT_W-1:0];
      vStartS <= vWindowWord[2*CNT_W-1:CNT_W];
      vEndS   <= vWindowWord[CNT_W-1:0];
      hsWS    <= hsyncWidth;
      vsWS    <= vsyncWidth;
    end
  end

  assign advance  = ctl.running & pixEn;
  assign lastCol  = (hCnt == hTotS - ONE);
  assign lastRow  = (vCnt == vTotS - ONE);
  assign frameEnd = advance & lastCol & lastRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt     <= '0;
      vCnt     <= '0;
      pixPhase <= 1'b0;
    end else begin
      pixPhase <= advance;
      if (ctl.clearCnt) begin
        hCnt <= '0;
        vCnt <= '0;
      end else if (advance) begin
        if (lastCol) begin
          hCnt <= '0;
          vCnt <= lastRow ? '0 : vCnt + ONE;
        end else begin
          hCnt <= hCnt + ONE;
        end
      end
    end
  end

  assign hsAct = ctl.running & (hCnt < {{PAD_W{1'b0}}, hsWS});
  assign vsAct = ctl.running & (vCnt < {{PAD_W{1'b0}}, vsWS});
  assign inH   = (hCnt >= hStartS) & (hCnt < hEndS);
  assign inV   = (vCnt >= vStartS) & (vCnt < vEndS);
  assign deAct = ctl.running & inH & inV;

  assign hsyncOut = hsAct ^ hsyncLow;
  assign vsyncOut = vsAct ^ vsyncLow;
  assign deOut    = deAct ^ deLow;
  assign pclkOut  = ctl.running & (pixPhase ~^ fallEdge);
  assign xPos     = deAct ? hCnt - hStartS : '0;
  assign yPos     = deAct ? vCnt - vStartS : '0;
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import raster_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic [SYNC_W-1:0]  hsyncWidth,
  input  logic [SYNC_W-1:0]  vsyncWidth,
  input  logic [2*CNT_W-1:0] totalWord,
  input  logic [2*CNT_W-1:0] hWindowWord,
  input  logic [2*CNT_W-1:0] vWindowWord,
  input  logic               hsyncLow,
  input  logic               vsyncLow,
  input  logic               deLow,
  input  logic               fallEdge,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic               stoppedClr,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               pclkOut,
  output logic [CNT_W-1:0]   xPos,
  output logic [CNT_W-1:0]   yPos,
  output logic               stoppedFlag
);
  rasterCtl_t ctl;
  logic       frameEnd;

  raster_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .stopReq     (stopReq),
    .stoppedClr  (stoppedClr),
    .frameEnd    (frameEnd),
    .ctl         (ctl),
    .stoppedFlag (stoppedFlag)
  );

  raster_datapath #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pixEn       (pixEn),
    .ctl         (ctl),
    .hsyncWidth  (hsyncWidth),
    .vsyncWidth  (vsyncWidth),
    .totalWord   (totalWord),
    .hWindowWord (hWindowWord),
    .vWindowWord (vWindowWord),
    .hsyncLow    (hsyncLow),
    .vsyncLow    (vsyncLow),
    .deLow       (deLow),
    .fallEdge    (fallEdge),
    .hsyncOut    (hsyncOut),
    .vsyncOut    (vsyncOut),
    .deOut       (deOut),
    .pclkOut     (pclkOut),
    .xPos        (xPos),
    .yPos        (yPos),
    .frameEnd    (frameEnd)
  );
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             running,
  input logic             frameEnd,
  input logic             stoppedFlag,
  input logic             stoppedClr,
  input logic             deOut,
  input logic             deLow,
  input logic             pclkOut,
  input logic [CNT_W-1:0] xPos,
  input logic [CNT_W-1:0] yPos
);
  // R8
  stop_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stoppedFlag) && $past(running)) |-> $past(frameEnd));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stoppedFlag && !stoppedClr) |=> stoppedFlag);

  // R5
  de_quiet_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (deOut == deLow));

  // R7
  pclk_quiet_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !pclkOut);

  // R5
  coord_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deOut == deLow) |-> (xPos == '0 && yPos == '0));

  // R8
  no_stop_midframe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !frameEnd) |=> running);
endmodule

bind lcd_raster_timing lcd_raster_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .running     (ctl.running),
  .frameEnd    (frameEnd),
  .stoppedFlag (stoppedFlag),
  .stoppedClr  (stoppedClr),
  .deOut       (deOut),
  .deLow       (deLow),
  .pclkOut     (pclkOut),
  .xPos        (xPos),
  .yPos        (yPos)
);

// File: tb/lcd_raster_timing_bench.sv
module lcd_raster_timing_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pixEn;
  logic [9:0]  hsyncWidth, vsyncWidth;
  logic [31:0] totalWord, hWindowWord, vWindowWord;
  logic        hsyncLow, vsyncLow, deLow, fallEdge;
  logic        startReq, stopReq, stoppedClr;
  logic        hsyncOut, vsyncOut, deOut, pclkOut, stoppedFlag;
  logic [15:0] xPos, yPos;

  int checks = 0;
  int fails  = 0;

  int gHTot, gVTot, gHs0, gHs1, gVs, gHa, gHe, gVa, gVe;
  bit gHl, gVl, gDl, gFe;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_timing u_lcd_raster_timing (
    .clk(clk), .rstN(rstN), .pixEn(pixEn),
    .hsyncWidth(hsyncWidth), .vsyncWidth(vsyncWidth),
    .totalWord(totalWord), .hWindowWord(hWindowWord), .vWindowWord(vWindowWord),
    .hsyncLow(hsyncLow), .vsyncLow(vsyncLow), .deLow(deLow), .fallEdge(fallEdge),
    .startReq(startReq), .stopReq(stopReq), .stoppedClr(stoppedClr),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pclkOut(pclkOut),
    .xPos(xPos), .yPos(yPos), .stoppedFlag(stoppedFlag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic applyCfg();
    hsyncWidth  = 10'(gHs0);
    vsyncWidth  = 10'(gVs);
    totalWord   = {16'(gHTot), 16'(gVTot)};
    hWindowWord = {16'(gHa), 16'(gHe)};
    vWindowWord = {16'(gVa), 16'(gVe)};
    hsyncLow = gHl; vsyncLow = gVl; deLow = gDl; fallEdge = gFe;
  endtask

  task automatic checkIdle(string req);
    chk({req, " hsync idle"}, int'(hsyncOut), int'(gHl));
    chk({req, " vsync idle"}, int'(vsyncOut), int'(gVl));
    chk({req, " de idle"}, int'(deOut), int'(gDl));
    chk({req, " pclk idle"}, int'(pclkOut), 0);
    chk({req, " x idle"}, int'(xPos), 0);
    chk({req, " y idle"}, int'(yPos), 0);
  endtask

  // expected outputs for pixel index n since start
  task automatic checkPix(int n, int stopN, bit ph);
    int frm, h, v, hs;
    bit inW;
    if (n >= stopN) begin
      checkIdle("R8");
      chk("R8 stopped flag at frame end", int'(stoppedFlag), 1);
    end else begin
      frm = n / (gHTot * gVTot);
      h   = n % gHTot;
      v   = (n / gHTot) % gVTot;
      hs  = (frm == 0) ? gHs0 : gHs1;
      inW = (h >= gHa) && (h < gHe) && (v >= gVa) && (v < gVe);
      chk("R4/R6/R10 hsync", int'(hsyncOut), int'((h < hs) ^ gHl));
      chk("R4/R6 vsync", int'(vsyncOut), int'((v < gVs) ^ gVl));
      chk("R5/R6 de", int'(deOut), int'(inW ^ gDl));
      chk("R5 xPos", int'(xPos), inW ? h - gHa : 0);
      chk("R5 yPos", int'(yPos), inW ? v - gVa : 0);
      chk("R7 pclk", int'(pclkOut), int'(ph == gFe));
      chk("R8 flag low while running", int'(stoppedFlag), 0);
    end
  endtask

  // R3: counts advance only on pixEn steps; second sample per step checks hold
  task automatic runSeq(int total, int disAt, int chgAt);
    int frameSz;
    int stopN;
    frameSz = gHTot * gVTot;
    stopN = (disAt >= 0) ? (disAt / frameSz + 1) * frameSz : 1 << 30;
    checkPix(0, stopN, 1'b0);
    for (int k = 0; k < total; k++) begin
      pixEn   = 1'b1;
      stopReq = (k == disAt);
      if (k == chgAt) hsyncWidth = 10'(gHs1);
      @(negedge clk);
      pixEn   = 1'b0;
      stopReq = 1'b0;
      checkPix(k + 1, stopN, 1'b1);
      @(negedge clk);
      checkPix(k + 1, stopN, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    gHTot = 8; gVTot = 5; gHs0 = 2; gHs1 = 3; gVs = 1;
    gHa = 3; gHe = 7; gVa = 2; gVe = 4;
    gHl = 0; gVl = 0; gDl = 0; gFe = 0;
    applyCfg();
    rstN = 1'b0; pixEn = 1'b0; startReq = 1'b0; stopReq = 1'b0; stoppedClr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkIdle("R1");
    chk("R1 flag after reset", int'(stoppedFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // R2 start, three frames with a mid-frame width change (R10), stop mid-frame (R8)
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    runSeq(122, 85, 10);

    // R9 sticky flag and clear
    @(negedge clk);
    chk("R9 flag holds", int'(stoppedFlag), 1);
    stoppedClr = 1'b1;
    @(negedge clk);
    stoppedClr = 1'b0;
    chk("R9 flag cleared", int'(stoppedFlag), 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R9 stop while stopped sets flag", int'(stoppedFlag), 1);

    // R2 start with stop high is ignored
    startReq = 1'b1; stopReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0;
    @(negedge clk);
    chk("R2 start blocked by stop", int'(pclkOut), 0);
    checkIdle("R2");
    stoppedClr = 1'b1;
    @(negedge clk);
    stoppedClr = 1'b0;

    // R6/R7 inverted polarities and falling edge, stop on last pixel (R8)
    gHs0 = 1; gHs1 = 1; gVs = 2;
    gHa = 2; gHe = 6; gVa = 1; gVe = 5;
    gHl = 1; gVl = 1; gDl = 1; gFe = 1;
    applyCfg();
    @(negedge clk);
    checkIdle("R6");
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    runSeq(42, 39, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule